// File: doc/BRIEF.md
# Cyclic Repeat Transfer Channel

This block is one transfer channel that runs endlessly over a table in memory. Each activation request makes the channel move one byte or one word between a 24-bit memory pointer and a fixed I/O location. The I/O location is an 8-bit offset placed in the top 256-byte page of the address space. An 8-bit live counter tracks how many transfers are left in the current pass. When the pass ends, the counter reloads from its initial count and the memory pointer returns to its starting value. The channel then keeps running with no further software action. A typical use is feeding a pattern table, one entry per timer tick, to an output port.

The direction of each transfer follows from which source raised the request. A request from the serial-receive "data full" source reads the I/O location and writes memory. Every other source reads memory and writes the I/O location. The bus side is a simple master with no wait states. Each transfer is one read cycle followed by one write cycle, and read data is sampled at the end of the read cycle.

Software sets the channel up through a small write port. Register select values are: 0 memory pointer, 1 I/O offset, 2 initial count, 3 control. The control bits are [0] enable, [1] word size and [2] count down.

Top module: `rpt_xfer_chan`

## Requirements
- R1: Each accepted request produces exactly one read cycle (bus_en=1, bus_wr=0) in the next cycle, then one write cycle (bus_en=1, bus_wr=1) in the cycle after. The write data is the data sampled in the read cycle.
- R2: After each transfer the memory pointer moves by 1 in byte mode or by 2 in word mode. It moves up when control bit 2 is 0 and down when control bit 2 is 1.
- R3: The I/O bus address is 16'hFFFF joined with the 8-bit offset. It does not change from transfer to transfer.
- R4: The live counter drops by one per transfer. The transfer that brings it to zero also reloads it from the initial count and returns the memory pointer to its saved start value.
- R5: An initial count of 0 gives a pass of 256 transfers before the reload.
- R6: If the request source ID equals 4 (serial receive full), the read goes to the I/O address and the write goes to the memory address. For any other ID, the read goes to memory and the write goes to the I/O address.
- R7: In word mode, bit 0 of both bus addresses is 0. In byte mode, bus_wdata[15:8] is 0 and bus_wdata[7:0] carries the byte read.
- R8: busy is high during the read and write cycles of a transfer. One request that arrives while busy is held and served after the current transfer, with its own source ID. Further requests arriving while one is held are dropped.
- R9: While the channel is disabled, requests start no bus cycle. While it is enabled or busy, writes to the pointer, offset and count registers are ignored.
- R10: A write to the memory pointer while the channel is disabled and idle sets both the live pointer and the saved start value used for reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 pointer, 1 I/O offset, 2 count, 3 control) |
| cfg_wdata | input | 24 | Register write data |
| req | input | 1 | Activation request |
| req_src | input | 3 | Source ID of the request |
| busy | output | 1 | Transfer in progress |
| bus_en | output | 1 | Bus cycle active |
| bus_wr | output | 1 | 1 for a write cycle, 0 for a read cycle |
| bus_word | output | 1 | 1 for a word access, 0 for a byte access |
| bus_addr | output | 24 | Bus address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, sampled at the end of a read cycle |

## Verification
A wrong pointer step or a missed reload does not stay hidden. It shows on bus_addr in the very next transfer's memory-side cycle, and every later transfer repeats the error. A miscounted live counter shows up as a reload that comes one transfer early or late, so the bench runs each pass past its reload point and checks the address of every cycle. A wrong direction latch or a mishandled pending request shows within two cycles, as swapped read and write addresses or as a bus cycle that is missing or extra.

// File: rtl/rpt_xfer_chan.sv
module rpt_xfer_chan #(
  parameter int AW = 24,
  parameter int IOW = 8,
  parameter int CW = 8,
  parameter int DW = 16,
  parameter int SRCW = 3,
  parameter logic [SRCW-1:0] RX_SRC = 3'd4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [AW-1:0]   cfg_wdata,
  input  logic            req,
  input  logic [SRCW-1:0] req_src,
  output logic            busy,
  output logic            bus_en,
  output logic            bus_wr,
  output logic            bus_word,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  input  logic [DW-1:0]   bus_rdata
);
  localparam int PAGE = AW - IOW;
  localparam int HW = DW / 2;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;
  st_t state;

  logic [AW-1:0]   mar, shadow;
  logic [IOW-1:0]  ioar;
  logic [CW-1:0]   live, init;
  logic            en, word, dec, from_io, pend;
  logic [SRCW-1:0] pend_src;
  logic [DW-1:0]   data;

  wire start = en && state == S_IDLE && (pend || req);
  wire [SRCW-1:0] start_src = pend ? pend_src : req_src;
  wire cfg_ok = !en && state == S_IDLE;
  wire [AW-1:0] step = word ? AW'(2) : AW'(1);
  wire [AW-1:0] mem_a = {mar[AW-1:1], mar[0] & ~word};
  wire [AW-1:0] io_a = {{PAGE{1'b1}}, ioar[IOW-1:1], ioar[0] & ~word};

  assign busy = state != S_IDLE;
  assign bus_en = busy;
  assign bus_wr = state == S_WR;
  assign bus_word = word;
  assign bus_addr = (state == S_RD) ? (from_io ? io_a : mem_a) :
                    (state == S_WR) ? (from_io ? mem_a : io_a) : '0;
  assign bus_wdata = word ? data : {{HW{1'b0}}, data[HW-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      mar <= '0; shadow <= '0; ioar <= '0;
      live <= '0; init <= '0;
      en <= 1'b0; word <= 1'b0; dec <= 1'b0;
      from_io <= 1'b0; pend <= 1'b0; pend_src <= '0; data <= '0;
    end else begin
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: if (cfg_ok) begin mar <= cfg_wdata; shadow <= cfg_wdata; end
          2'd1: if (cfg_ok) ioar <= cfg_wdata[IOW-1:0];
          2'd2: if (cfg_ok) begin init <= cfg_wdata[CW-1:0]; live <= cfg_wdata[CW-1:0]; end
          default: {dec, word, en} <= cfg_wdata[2:0];
        endcase
      end

      if (!en) pend <= 1'b0;
      else if (state == S_IDLE) begin
        if (pend && req) pend_src <= req_src;
        else if (pend) pend <= 1'b0;
      end else if (req && !pend) begin
        pend <= 1'b1;
        pend_src <= req_src;
      end

      case (state)
        S_IDLE: if (start) begin
          state <= S_RD;
          from_io <= start_src == RX_SRC;
        end
        S_RD: begin
          data <= bus_rdata;
          state <= S_WR;
        end
        default: begin
          state <= S_IDLE;
          if (live == CW'(1)) begin
            live <= init;
            mar <= shadow;
          end else begin
            live <= live - 1'b1;
            mar <= dec ? mar - step : mar + step;
          end
        end
      endcase
    end
  end

  // R1
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> $past(bus_en && !bus_wr));

  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WR && live == CW'(1)) |=> (live == init && mar == shadow));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WR && live != CW'(1)) |=> live == CW'($past(live) - 1'b1));

  // R9
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !en) |=> !busy);

  // R10
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(shadow));

  // R3
  io_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ioar));
endmodule

// File: tb/tb_rpt_xfer_chan.sv
module tb_rpt_xfer_chan;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0, cfg_we = 0, req = 0;
  logic [1:0] cfg_sel = 0;
  logic [23:0] cfg_wdata = 0;
  logic [2:0] req_src = 0;
  logic busy, bus_en, bus_wr, bus_word;
  logic [23:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;

  rpt_xfer_chan dut (.clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .req, .req_src,
    .busy, .bus_en, .bus_wr, .bus_word, .bus_addr, .bus_wdata, .bus_rdata);

  always #(CLK_NS/2) clk = ~clk;
  assign bus_rdata = bus_addr[15:0] ^ 16'h5A3C ^ {bus_addr[23:16], 8'h00};

  int total = 0, bad = 0;
  logic [23:0] m_mar, m_sh;
  logic [7:0] m_io, m_live, m_init;
  logic m_word, m_dec;

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic logic [15:0] rd_of(input logic [23:0] a);
    return a[15:0] ^ 16'h5A3C ^ {a[23:16], 8'h00};
  endfunction

  task automatic cfg(input logic [1:0] s, input logic [23:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  // at negedge in read cycle: check read and write cycles, update model
  task automatic run_cycles(input logic [2:0] src);
    logic [23:0] ma, ia, ea;
    logic [15:0] ew;
    bit rx;
    rx = (src == 3'd4);
    ma = m_word ? {m_mar[23:1], 1'b0} : m_mar;
    ia = {16'hFFFF, m_io[7:1], m_io[0] & ~m_word};
    ea = rx ? ia : ma;
    chk(bus_en && !bus_wr && busy, "R1 read cycle", {29'd0, bus_en, bus_wr, busy}, 32'h5);
    chk(bus_addr == ea, rx ? "R6 read addr (rx)" : "R2 R6 read addr", bus_addr, ea);
    if (m_word) chk(!bus_addr[0], "R7 word align", bus_addr, ea);
    ew = m_word ? rd_of(ea) : {8'h00, rd_of(ea)[7:0]};
    @(negedge clk);
    chk(bus_en && bus_wr && busy, "R1 write cycle", {29'd0, bus_en, bus_wr, busy}, 32'h7);
    chk(bus_addr == (rx ? ma : ia), rx ? "R3 R6 write addr (rx)" : "R3 write addr", bus_addr, rx ? ma : ia);
    chk(bus_wdata == ew, "R7 write data", bus_wdata, ew);
    chk(bus_word == m_word, "R7 size", bus_word, m_word);
    if (m_live == 8'd1) begin
      m_live = m_init; m_mar = m_sh;
    end else begin
      m_live = m_live - 1;
      m_mar = m_dec ? m_mar - (m_word ? 24'd2 : 24'd1) : m_mar + (m_word ? 24'd2 : 24'd1);
    end
  endtask

  task automatic xfer(input logic [2:0] src);
    @(negedge clk); req = 1; req_src = src;
    @(negedge clk); req = 0;
    run_cycles(src);
    @(negedge clk);
    chk(!busy && !bus_en, "R8 busy ends", busy, 0);
  endtask

  task automatic setup(input logic w, input logic d, input logic [23:0] base, input logic [7:0] io, input logic [7:0] n);
    cfg(2'd3, {21'd0, d, w, 1'b0});
    cfg(2'd0, base);
    cfg(2'd1, {16'd0, io});
    cfg(2'd2, {16'd0, n});
    cfg(2'd3, {21'd0, d, w, 1'b1});
    m_word = w; m_dec = d; m_mar = base; m_sh = base; m_io = io; m_live = n; m_init = n;
  endtask

  initial begin
    #(CLK_NS * 150000);
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !bus_en && !bus_wr, "R1 reset idle", {busy, bus_en, bus_wr}, 0);

    // sweep: size, direction, source, initial count; run past reload
    for (int w = 0; w < 2; w++)
      for (int d = 0; d < 2; d++)
        for (int s = 0; s < 2; s++)
          for (int n = 0; n < 4; n++) begin
            setup(w[0], d[0], 24'h123457 + 24'(n * 16), 8'h3B + 8'(s), 8'(n));
            for (int k = 0; k < ((n == 0) ? 256 : n) + 2; k++)
              xfer(s ? 3'd1 : 3'd4); // R4 R5 reload crossing
          end

    // R9: disabled channel ignores requests
    cfg(2'd3, 24'd0);
    @(negedge clk); req = 1; req_src = 3'd1;
    @(negedge clk); req = 0;
    for (int i = 0; i < 3; i++) begin
      chk(!bus_en && !busy, "R9 disabled ignores req", bus_en, 0);
      @(negedge clk);
    end

    // R10: pointer write while disabled sets start value; R9 writes while enabled ignored
    setup(1'b0, 1'b0, 24'h000100, 8'h20, 8'd2);
    cfg(2'd0, 24'h00ABCD);
    cfg(2'd1, 24'h000077);
    cfg(2'd2, 24'h000009);
    xfer(3'd2); // R9 old pointer, offset used
    xfer(3'd2);
    xfer(3'd2); // R10 reload to start value

    // R8: pending request held, third dropped
    setup(1'b1, 1'b0, 24'h000400, 8'h10, 8'd5);
    @(negedge clk); req = 1; req_src = 3'd1;
    @(negedge clk); req = 1; req_src = 3'd4;
    run_cycles(3'd1);
    req = 1; req_src = 3'd2;
    @(negedge clk); req = 0;
    chk(!busy, "R8 gap between transfers", busy, 0);
    @(negedge clk);
    run_cycles(3'd4); // R8 held request uses its own source
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!bus_en, "R8 extra request dropped", bus_en, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule